// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an up-counting timer with a small register interface. The input clock passes through a power-of-two prescaler. Each prescaled tick either advances the count or, when the count already equals the period register, returns it to zero. Every such period match advances a postscaler. When the postscaler reaches its programmed ratio, a sticky interrupt flag is raised. Software clears the flag by writing a one to it. The flag reaches the interrupt line only while the enable bit is set.

Software writes registers through a one-cycle write strobe and reads them through a combinational read mux. The register map is: address 0 holds the count, address 1 the period, address 2 control and address 3 status. Control holds the prescale code in bits [2:0], the postscale code k in bits [6:3] (ratio k+1) and the interrupt enable in bit 7. Status holds the flag in bit 0.

A synchronous external clear input restarts the timer. Writing the count or control register restarts both divider chains.

The count path picks one action per cycle from the enumerated set ACT_EXTCLR, ACT_LOAD, ACT_HOLD, ACT_WRAP and ACT_INC, in that order of priority. The flag is a two-state machine:
- FLAG_IDLE moves to FLAG_RAISED on a postscaled event.
- FLAG_RAISED returns to FLAG_IDLE on a software clear, but only when no event arrives in the same cycle.
- Otherwise each state holds.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0x00, the period 0xFF, control 0x00, status 0x00, and irq is low.
- R2: With prescale code n (control bits [2:0]), the count advances once every 2^n clocks. After a restart it first advances 2^n clocks later. Without a tick or a write, the count holds.
- R3: On a tick where the count equals the period, the count becomes 0 instead of incrementing. With a period of 0 the count stays at 0.
- R4: With postscale code k (control bits [6:3]), the flag sets on every (k+1)-th period match.
- R5: A write to address 0 loads the count and restarts the prescaler and postscaler.
- R6: A write to address 2 loads control and restarts both dividers, and it leaves the count unchanged.
- R7: ext_clr zeroes the count and restarts both dividers, and it takes priority over a count write in the same cycle.
- R8: The flag (status bit 0) stays set until a write to address 3 with bit 0 high. If a postscaled event occurs in the same cycle as that write, the flag stays set.
- R9: irq equals the flag ANDed with control bit 7.
- R10: The period register at address 1 is readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clr | input | 1 | Synchronous external timer clear |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Read data (combinational) |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench builds the block with the default 8-bit count. This gives prescale codes 0 to 7 and postscale codes 0 to 15, so every divider ratio can be reached in a few hundred cycles. Random traffic keeps the period small and mostly selects low prescale codes, so matches, postscaled events and software clears often collide with one another. Directed sequences pin the exact cycle of the first match and of the flag set. They also cover a clear arriving together with an event, and an external clear arriving together with a count write.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int PRE_SEL_W  = 3;
    localparam int POST_SEL_W = 4;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_PERIOD = 2'd1,
        REG_CTRL   = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_WRAP,
        ACT_LOAD,
        ACT_EXTCLR
    } cnt_act_e;

    typedef enum logic {
        FLAG_IDLE,
        FLAG_RAISED
    } flag_state_e;

    typedef struct packed {
        logic                  irq_en;
        logic [POST_SEL_W-1:0] post_sel;
        logic [PRE_SEL_W-1:0]  pre_sel;
    } ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    assign tick = &(div_q | ~mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tick == (sel == '0)));                                   // R5

endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] sel,
    output logic         evt
);
    logic [W-1:0] post_q;

    assign evt = adv && !clr && (post_q == sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_q <= '0;
        end else if (clr) begin
            post_q <= '0;
        end else if (adv) begin
            post_q <= evt ? '0 : post_q + 1'b1;
        end
    end

    AST_POST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        post_q <= sel);                                                   // R4

endmodule

// File: rtl/tmr_flag_fsm.sv
module tmr_flag_fsm
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic sw_clr,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (set_evt) state_d = FLAG_RAISED;
            FLAG_RAISED: if (sw_clr && !set_evt) state_d = FLAG_IDLE;
            default:     state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLAG_RAISED);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);                                                // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !sw_clr) |=> flag);                                      // R8

endmodule

// File: rtl/period_timer.sv
module period_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clr,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [CNT_W-1:0] cnt_q, per_q;
    ctrl_t            ctrl_q;
    logic             wr_cnt, wr_per, wr_ctrl, wr_stat;
    logic             div_clr, tick, match, post_evt, flag;
    cnt_act_e         act;

    always_comb begin
        wr_cnt  = wr_en && (reg_sel_e'(wr_addr) == REG_COUNT);
        wr_per  = wr_en && (reg_sel_e'(wr_addr) == REG_PERIOD);
        wr_ctrl = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);
        wr_stat = wr_en && (reg_sel_e'(wr_addr) == REG_STATUS);
    end

    assign div_clr = ext_clr || wr_cnt || wr_ctrl;
    assign match   = tick && (cnt_q == per_q);

    tmr_prescaler #(.SEL_W(PRE_SEL_W)) pre_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (div_clr),
        .sel  (ctrl_q.pre_sel),
        .tick (tick)
    );

    tmr_postscaler #(.W(POST_SEL_W)) post_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (div_clr),
        .adv  (match),
        .sel  (ctrl_q.post_sel),
        .evt  (post_evt)
    );

    tmr_flag_fsm flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(post_evt),
        .sw_clr (wr_stat && wr_data[0]),
        .flag   (flag)
    );

    always_comb begin
        if (ext_clr)     act = ACT_EXTCLR;
        else if (wr_cnt) act = ACT_LOAD;
        else if (!tick)  act = ACT_HOLD;
        else if (match)  act = ACT_WRAP;
        else             act = ACT_INC;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_EXTCLR: cnt_q <= '0;
                ACT_LOAD:   cnt_q <= wr_data;
                ACT_HOLD:   cnt_q <= cnt_q;
                ACT_WRAP:   cnt_q <= '0;
                ACT_INC:    cnt_q <= cnt_q + 1'b1;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '1;
            ctrl_q <= '0;
        end else begin
            if (wr_per)  per_q  <= wr_data;
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_addr))
            REG_COUNT:  rd_data = cnt_q;
            REG_PERIOD: rd_data = per_q;
            REG_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
            REG_STATUS: rd_data[0] = flag;
            default:    rd_data = '0;
        endcase
    end

    assign irq = flag && ctrl_q.irq_en;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_q == per_q) && !ext_clr && !wr_cnt) |=> (cnt_q == '0)); // R3
    AST_EXT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr |=> (cnt_q == '0));                                       // R7
    AST_CTRL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !ext_clr && !tick) |=> $stable(cnt_q));               // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ext_clr && !wr_cnt) |=> $stable(cnt_q));               // R2

endmodule

// File: tb/period_timer_tb.sv
module period_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, ext_clr, wr_en;
    logic [1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       irq;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    logic [7:0] m_cnt, m_per, m_ctrl;
    int         m_pre, m_post;
    logic       m_flag;

    always #10 clk = ~clk;

    period_timer #(.CNT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_clr(ext_clr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [7:0] model_read(input int a);
        case (a)
            0:       return m_cnt;
            1:       return m_per;
            2:       return m_ctrl;
            default: return {7'd0, m_flag};
        endcase
    endfunction

    task automatic check_all();
        logic [7:0] v;
        string names[4] = '{"R2 count", "R10 period", "R6 ctrl", "R8 status"};
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(names[a], v, model_read(a));
        end
        chk("R9 irq", {7'd0, irq}, {7'd0, m_flag & m_ctrl[7]});
    endtask

    task automatic step(input bit we, input logic [1:0] a, input logic [7:0] d, input bit ext);
        int  ratio;
        bit  tick, clr, match, ev;
        wr_en = we; wr_addr = a; wr_data = d; ext_clr = ext;
        @(posedge clk);
        ratio = 1 << m_ctrl[2:0];
        tick  = ((m_pre % ratio) == ratio - 1);
        clr   = ext || (we && a == 2'd0) || (we && a == 2'd2);
        match = tick && (m_cnt == m_per);
        ev    = 1'b0;
        if (clr) m_post = 0;
        else if (match) begin
            if (m_post == int'(m_ctrl[6:3])) begin m_post = 0; ev = 1'b1; end
            else m_post++;
        end
        if (ext)                       m_cnt = 8'd0;
        else if (we && a == 2'd0)      m_cnt = d;
        else if (tick)                 m_cnt = match ? 8'd0 : m_cnt + 8'd1;
        m_pre = clr ? 0 : (m_pre + 1) % 128;
        if (ev)                                m_flag = 1'b1;
        else if (we && a == 2'd3 && d[0])      m_flag = 1'b0;
        if (we && a == 2'd1) m_per  = d;
        if (we && a == 2'd2) m_ctrl = d;
        @(negedge clk);
        wr_en = 1'b0; ext_clr = 1'b0;
        check_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'd0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ext_clr = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_cnt = 0; m_per = 8'hFF; m_ctrl = 0; m_pre = 0; m_post = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(2'd0, v); chk("R1 count reset", v, 8'h00);
        rd(2'd1, v); chk("R1 period reset", v, 8'hFF);
        rd(2'd2, v); chk("R1 ctrl reset", v, 8'h00);
        rd(2'd3, v); chk("R1 status reset", v, 8'h00);
        chk("R1 irq reset", {7'd0, irq}, 8'h00);

        // R2: divide by 4, count 2 after 8 clocks
        step(1'b1, 2'd2, 8'h02, 1'b0);
        step(1'b1, 2'd0, 8'h00, 1'b0);
        idle(7);
        rd(2'd0, v); chk("R2 count before 8th clock", v, 8'h01);
        idle(1);
        rd(2'd0, v); chk("R2 count after 8 clocks", v, 8'h02);

        // R3: period 0 keeps count at 0
        step(1'b1, 2'd1, 8'h00, 1'b0);
        step(1'b1, 2'd2, 8'h00, 1'b0);
        step(1'b1, 2'd0, 8'h00, 1'b0);
        idle(5);
        rd(2'd0, v); chk("R3 period zero holds count", v, 8'h00);

        // R4: period 1, divide by 4, postscale 1:2, irq enabled
        step(1'b1, 2'd1, 8'h01, 1'b0);
        step(1'b1, 2'd2, 8'h8A, 1'b0);
        step(1'b1, 2'd3, 8'h01, 1'b0);
        step(1'b1, 2'd0, 8'h00, 1'b0);
        idle(15);
        rd(2'd3, v); chk("R4 flag not yet", v, 8'h00);
        idle(1);
        rd(2'd3, v); chk("R4 flag on second match", v, 8'h01);
        chk("R9 irq with enable", {7'd0, irq}, 8'h01);

        // R8: clear coinciding with next event -> set wins
        idle(15);
        step(1'b1, 2'd3, 8'h01, 1'b0);
        rd(2'd3, v); chk("R8 set wins over clear", v, 8'h01);

        // R9: disable gates irq while flag stays
        step(1'b1, 2'd2, 8'h0A, 1'b0);
        chk("R9 irq gated off", {7'd0, irq}, 8'h00);
        rd(2'd3, v); chk("R8 flag sticky across ctrl write", v, 8'h01);
        step(1'b1, 2'd3, 8'h01, 1'b0);
        rd(2'd3, v); chk("R8 software clear", v, 8'h00);

        // R7: external clear beats count write
        step(1'b1, 2'd0, 8'h33, 1'b1);
        rd(2'd0, v); chk("R7 ext clear wins", v, 8'h00);

        // R5: count load
        step(1'b1, 2'd1, 8'hFF, 1'b0);
        step(1'b1, 2'd0, 8'h40, 1'b0);
        rd(2'd0, v); chk("R5 count load", v, 8'h40);

        // R6: ctrl write leaves count
        step(1'b1, 2'd0, 8'h20, 1'b0);
        step(1'b1, 2'd2, 8'h03, 1'b0);
        rd(2'd0, v); chk("R6 count kept", v, 8'h20);

        // R10: period readback
        step(1'b1, 2'd1, 8'h5C, 1'b0);
        rd(2'd1, v); chk("R10 period readback", v, 8'h5C);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int  r;
            bit  we, ext;
            logic [1:0] a;
            logic [7:0] d;
            r   = $urandom_range(0, 99);
            we  = (r < 10);
            ext = ($urandom_range(0, 63) == 0);
            a   = 2'($urandom_range(0, 3));
            d   = 8'($urandom);
            if (a == 2'd1) d = 8'($urandom_range(0, 7));
            if (a == 2'd2) d[2:0] = 3'($urandom_range(0, 3));
            if (a == 2'd0) d = 8'($urandom_range(0, 9));
            step(we, a, d, ext);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule